// File: doc/BRIEF.md
# SPI Boot Command Packet Receiver

This block is the target end of a boot-time command channel that a host drives over an SPI slave link. It sits behind a byte deserializer that delivers one received byte per strobe. It also supplies the byte to return during the next transfer. Every chip-select frame opens with six host bytes. While they arrive, the receiver answers with a six-byte status header: a ready flag, three zero bytes, a fixed marker and the number of 16-bit words it expects after the header.

The receiver has two phases. In the command phase it expects a 12-byte packet made of a 16-bit header identifier, a 16-bit command code and two 32-bit arguments. All fields are big-endian. A packet with a good identifier is output as a one-cycle command strobe with its code, a one-hot decode and both arguments. A packet with a bad identifier raises an error pulse instead. A print-text command switches the receiver to the data phase for the next frame. In that frame it advertises half the announced byte length as its word count and streams that many bytes out as payload. It then returns to the command phase.

Top module: `spi_boot_rx`

## Requirements
- R1: The status byte offered for frame byte index 0 is 0x01 when target_ready is high and 0x00 when it is low. Indices 1 to 3 offer 0x00, index 4 offers 0x80, index 5 offers the expected word count, and every later index offers 0x00. tx_byte is valid from the second clock after the previous byte strobe, and from the second clock after chip select rises.
- R2: The values of the six host header bytes have no effect.
- R3: In the command phase, the 12 bytes after the header are taken as header ID (bytes 6-7), command code (bytes 8-9), first argument (bytes 10-13) and second argument (bytes 14-17), all most significant byte first. When the ID equals 0xAACA, cmd_valid is high for one cycle, on the clock after the strobe of byte 17, with cmd_code, cmd_arg0 and cmd_arg1 holding the fields.
- R4: cmd_sel is one-hot when the code is known: bit 0 for 0x0001 (print text), bit 1 for 0x0002 (upload memory), bit 2 for 0x0003 (restart), bit 3 for 0x0004 (clear memory). Any other code gives cmd_valid with cmd_sel of zero.
- R5: A packet whose ID is not 0xAACA gives a one-cycle hdr_err pulse and no cmd_valid, and the receiver stays in the command phase.
- R6: After an accepted print-text command, the next frame advertises cmd_arg0[8:1] words at index 5. That frame streams the 2*words bytes after the header on pay_valid/pay_data, one clock after each strobe, with pay_done high together with the last byte. The receiver then returns to the command phase. With zero words, pay_done pulses one clock after byte 5 and no payload is emitted.
- R7: Bytes past the end of the command packet or the payload within a frame are ignored.
- R8: If the ready flag offered at index 0 was low, the rest of that frame is ignored and the phase does not change.
- R9: Dropping chip select before a packet completes discards it. The next frame restarts at index 0, and a full packet in it is decoded with no trace of the partial one.
- R10: During and after reset the receiver is in the command phase (index 5 offers 6 words), all strobes are low and tx_byte is 0x00 during reset.
- R11: Commands other than print text leave the receiver in the command phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_active | input | 1 | Chip select asserted (high = frame in progress) |
| rx_valid | input | 1 | Strobe: one host byte received |
| rx_byte | input | 8 | Received host byte |
| target_ready | input | 1 | Target can accept a packet or payload |
| tx_byte | output | 8 | Byte to return during the next transfer |
| cmd_valid | output | 1 | Accepted command strobe |
| cmd_sel | output | 4 | One-hot decode: print, upload, restart, clear |
| cmd_code | output | 16 | Raw command code |
| cmd_arg0 | output | 32 | First argument (length or base address) |
| cmd_arg1 | output | 32 | Second argument (offset or size) |
| hdr_err | output | 1 | Packet dropped for a bad header ID |
| pay_valid | output | 1 | Payload byte strobe |
| pay_data | output | 8 | Payload byte |
| pay_done | output | 1 | Last payload byte or empty payload complete |

## Verification
The assertions check every cycle that a command and a header error never coincide and that the decode is never multi-hot. They also check that every command or payload strobe follows a byte strobe taken while chip select was high, and that nothing is emitted while chip select is low. Only the bench's scenarios can show the status bytes, the field order of the packet and the phase sequence. The bench covers a print text followed by its data frame with an advertised count of half the length, including the empty payload. It also covers frames dropped by a low ready flag or a mid-packet chip-select release, and the return to the command phase afterwards.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;
  localparam int HDR_LEN    = 6;
  localparam int PKT_LEN    = 12;
  localparam int CMD_WORDS  = PKT_LEN / 2;
  localparam logic [7:0] STATUS_MARK = 8'h80;
  localparam int NUM_CMDS   = 4;

  typedef enum logic { PH_CMD = 1'b0, PH_DATA = 1'b1 } phase_e;
endpackage

// File: rtl/sbr_frame_track.sv
module sbr_frame_track #(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_active,
  input  logic             rx_valid,
  output logic             byte_stb,
  output logic [IDX_W-1:0] idx_q
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  assign byte_stb = rx_valid && cs_active;

  always_ff @(posedge clk) begin
    if (rst || !cs_active) begin
      idx_q <= '0;
    end else if (byte_stb && idx_q != IDX_MAX) begin
      idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/sbr_status_gen.sv
module sbr_status_gen
  import spi_boot_pkg::*;
#(
  parameter int IDX_W  = 10,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  idx_q,
  input  phase_e            phase,
  input  logic [WORD_W-1:0] words,
  input  logic              target_ready,
  output logic [7:0]        tx_byte
);
  logic [7:0] tx_d;

  always_comb begin
    tx_d = 8'h00;
    if (idx_q == IDX_W'(0)) begin
      tx_d = {7'b0, target_ready};
    end else if (idx_q == IDX_W'(4)) begin
      tx_d = STATUS_MARK;
    end else if (idx_q == IDX_W'(5)) begin
      if (phase == PH_DATA) tx_d = 8'(words);
      else                  tx_d = 8'(CMD_WORDS);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tx_byte <= 8'h00;
    else     tx_byte <= tx_d;
  end
endmodule

// File: rtl/sbr_cmd_assembler.sv
module sbr_cmd_assembler
  import spi_boot_pkg::*;
#(
  parameter int          IDX_W     = 10,
  parameter int          ARG_W     = 32,
  parameter logic [15:0] HEADER_ID = 16'hAACA
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                byte_stb,
  input  logic                enable,
  input  logic [IDX_W-1:0]    idx_q,
  input  logic [7:0]          rx_byte,
  output logic                cmd_valid,
  output logic                hdr_err,
  output logic [NUM_CMDS-1:0] cmd_sel,
  output logic [15:0]         cmd_code,
  output logic [ARG_W-1:0]    cmd_arg0,
  output logic [ARG_W-1:0]    cmd_arg1
);
  localparam int PKT_W = PKT_LEN * 8;
  localparam logic [IDX_W-1:0] FIRST_IDX = IDX_W'(HDR_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(HDR_LEN + PKT_LEN - 1);

  logic [PKT_W-9:0]        pkt_q;
  logic [PKT_W-1:0]        pkt_full;
  logic                    in_pkt;
  logic                    last_byte;
  logic [15:0]             f_id;
  logic [15:0]             f_code;
  logic [ARG_W-1:0]        f_a0;
  logic [ARG_W-1:0]        f_a1;
  logic [NUM_CMDS-1:0]     sel_d;

  assign in_pkt    = byte_stb && enable && idx_q >= FIRST_IDX && idx_q <= LAST_IDX;
  assign last_byte = in_pkt && idx_q == LAST_IDX;
  assign pkt_full  = {pkt_q, rx_byte};
  assign f_id      = pkt_full[PKT_W-1 -: 16];
  assign f_code    = pkt_full[PKT_W-17 -: 16];
  assign f_a0      = pkt_full[2*ARG_W-1 -: ARG_W];
  assign f_a1      = pkt_full[ARG_W-1:0];

  always_comb begin
    for (int k = 0; k < NUM_CMDS; k++) begin
      sel_d[k] = (f_code == 16'(k + 1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_q <= '0;
    end else if (in_pkt) begin
      pkt_q <= pkt_full[PKT_W-9:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      hdr_err   <= 1'b0;
      cmd_sel   <= '0;
      cmd_code  <= '0;
      cmd_arg0  <= '0;
      cmd_arg1  <= '0;
    end else begin
      cmd_valid <= last_byte && (f_id == HEADER_ID);
      hdr_err   <= last_byte && (f_id != HEADER_ID);
      if (last_byte && f_id == HEADER_ID) begin
        cmd_sel  <= sel_d;
        cmd_code <= f_code;
        cmd_arg0 <= f_a0;
        cmd_arg1 <= f_a1;
      end else begin
        cmd_sel  <= '0;
      end
    end
  end
endmodule

// File: rtl/sbr_payload_gate.sv
module sbr_payload_gate
  import spi_boot_pkg::*;
#(
  parameter int IDX_W  = 10,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_stb,
  input  logic              enable,
  input  logic [IDX_W-1:0]  idx_q,
  input  logic [7:0]        rx_byte,
  input  logic [WORD_W-1:0] words,
  output logic              pay_valid,
  output logic [7:0]        pay_data,
  output logic              pay_done
);
  localparam logic [IDX_W-1:0] FIRST_IDX = IDX_W'(HDR_LEN);

  logic [IDX_W-1:0] end_idx;
  logic             in_pay;
  logic             empty_end;

  assign end_idx   = FIRST_IDX + IDX_W'({words, 1'b0});
  assign in_pay    = byte_stb && enable && idx_q >= FIRST_IDX && idx_q < end_idx;
  assign empty_end = byte_stb && enable && words == '0 && idx_q == FIRST_IDX - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      pay_valid <= 1'b0;
      pay_data  <= 8'h00;
      pay_done  <= 1'b0;
    end else begin
      pay_valid <= in_pay;
      if (in_pay) pay_data <= rx_byte;
      pay_done  <= (in_pay && idx_q == end_idx - 1'b1) || empty_end;
    end
  end
endmodule

// File: rtl/spi_boot_rx.sv
module spi_boot_rx
  import spi_boot_pkg::*;
#(
  parameter int          ARG_W     = 32,
  parameter int          WORD_W    = 8,
  parameter logic [15:0] HEADER_ID = 16'hAACA
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs_active,
  input  logic                rx_valid,
  input  logic [7:0]          rx_byte,
  input  logic                target_ready,
  output logic [7:0]          tx_byte,
  output logic                cmd_valid,
  output logic [3:0]          cmd_sel,
  output logic [15:0]         cmd_code,
  output logic [ARG_W-1:0]    cmd_arg0,
  output logic [ARG_W-1:0]    cmd_arg1,
  output logic                hdr_err,
  output logic                pay_valid,
  output logic [7:0]          pay_data,
  output logic                pay_done
);
  localparam int IDX_W = $clog2(HDR_LEN + 2 * (2 ** WORD_W) + 1) + 1;

  logic              byte_stb;
  logic [IDX_W-1:0]  idx_q;
  phase_e            phase_q;
  logic [WORD_W-1:0] words_q;
  logic              frame_ok_q;
  phase_e            frame_phase_q;

  sbr_frame_track #(.IDX_W(IDX_W)) u_track (
    .clk(clk), .rst(rst), .cs_active(cs_active), .rx_valid(rx_valid),
    .byte_stb(byte_stb), .idx_q(idx_q)
  );

  sbr_status_gen #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_status (
    .clk(clk), .rst(rst), .idx_q(idx_q), .phase(phase_q), .words(words_q),
    .target_ready(target_ready), .tx_byte(tx_byte)
  );

  // Ready flag and phase are frozen at byte 0, as offered to the host.
  always_ff @(posedge clk) begin
    if (rst || !cs_active) begin
      frame_ok_q    <= 1'b0;
      frame_phase_q <= PH_CMD;
    end else if (byte_stb && idx_q == '0) begin
      frame_ok_q    <= tx_byte[0];
      frame_phase_q <= phase_q;
    end
  end

  sbr_cmd_assembler #(.IDX_W(IDX_W), .ARG_W(ARG_W), .HEADER_ID(HEADER_ID)) u_cmd (
    .clk(clk), .rst(rst), .byte_stb(byte_stb),
    .enable(frame_ok_q && frame_phase_q == PH_CMD),
    .idx_q(idx_q), .rx_byte(rx_byte),
    .cmd_valid(cmd_valid), .hdr_err(hdr_err), .cmd_sel(cmd_sel),
    .cmd_code(cmd_code), .cmd_arg0(cmd_arg0), .cmd_arg1(cmd_arg1)
  );

  sbr_payload_gate #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_pay (
    .clk(clk), .rst(rst), .byte_stb(byte_stb),
    .enable(frame_ok_q && frame_phase_q == PH_DATA),
    .idx_q(idx_q), .rx_byte(rx_byte), .words(words_q),
    .pay_valid(pay_valid), .pay_data(pay_data), .pay_done(pay_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_CMD;
      words_q <= '0;
    end else if (cmd_valid && cmd_sel[0]) begin
      phase_q <= PH_DATA;
      words_q <= cmd_arg0[WORD_W:1];
    end else if (pay_done) begin
      phase_q <= PH_CMD;
    end
  end
endmodule

// File: rtl/spi_boot_rx_chk.sv
module spi_boot_rx_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_active,
  input logic       rx_valid,
  input logic       cmd_valid,
  input logic [3:0] cmd_sel,
  input logic       hdr_err,
  input logic       pay_valid,
  input logic       pay_done
);
  a_r5_err_excludes_cmd: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && hdr_err));

  a_r4_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_sel));

  a_r4_sel_needs_valid: assert property (@(posedge clk) disable iff (rst)
    (cmd_sel != 4'b0) |-> cmd_valid);

  a_r9_quiet_when_deselected: assert property (@(posedge clk) disable iff (rst)
    !cs_active |=> !(cmd_valid || hdr_err || pay_valid || pay_done));

  a_r3_cmd_after_byte: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> $past(rx_valid && cs_active));

  a_r6_pay_after_byte: assert property (@(posedge clk) disable iff (rst)
    pay_valid |-> $past(rx_valid && cs_active));
endmodule

bind spi_boot_rx spi_boot_rx_chk u_chk (
  .clk(clk), .rst(rst), .cs_active(cs_active), .rx_valid(rx_valid),
  .cmd_valid(cmd_valid), .cmd_sel(cmd_sel), .hdr_err(hdr_err),
  .pay_valid(pay_valid), .pay_done(pay_done)
);

// File: tb/spi_boot_rx_test.sv
module spi_boot_rx_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_active = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        target_ready = 1'b1;
  logic [7:0]  tx_byte;
  logic        cmd_valid;
  logic [3:0]  cmd_sel;
  logic [15:0] cmd_code;
  logic [31:0] cmd_arg0, cmd_arg1;
  logic        hdr_err, pay_valid, pay_done;
  logic [7:0]  pay_data;

  int total = 0;
  int fails = 0;

  logic [7:0] fb [0:31];
  logic [7:0] tx_seen [0:31];
  logic [7:0] pay_buf [0:31];
  int cmd_cnt = 0, err_cnt = 0, pay_cnt = 0, done_cnt = 0, done_at = 0;
  logic [3:0]  last_sel;
  logic [15:0] last_code;
  logic [31:0] last_a0, last_a1;

  always #5 clk = ~clk;

  spi_boot_rx uut (
    .clk(clk), .rst(rst), .cs_active(cs_active), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .target_ready(target_ready), .tx_byte(tx_byte),
    .cmd_valid(cmd_valid), .cmd_sel(cmd_sel), .cmd_code(cmd_code),
    .cmd_arg0(cmd_arg0), .cmd_arg1(cmd_arg1), .hdr_err(hdr_err),
    .pay_valid(pay_valid), .pay_data(pay_data), .pay_done(pay_done)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (pay_valid) begin
        pay_buf[pay_cnt % 32] = pay_data;
        pay_cnt++;
      end
      if (pay_done) begin
        done_cnt++;
        done_at = pay_cnt;
      end
      if (cmd_valid) begin
        cmd_cnt++;
        last_sel = cmd_sel; last_code = cmd_code;
        last_a0 = cmd_arg0; last_a1 = cmd_arg1;
      end
      if (hdr_err) err_cnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic send_frame(input int n);
    @(negedge clk); cs_active = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      tx_seen[i] = tx_byte;
      rx_byte = fb[i]; rx_valid = 1'b1;
      @(negedge clk); rx_valid = 1'b0;
      repeat (3) @(negedge clk);
    end
    cs_active = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic build_cmd(input logic [7:0] h0, input logic [7:0] h1,
                           input logic [15:0] id, input logic [15:0] code,
                           input logic [31:0] a0, input logic [31:0] a1);
    fb[0] = h0; fb[1] = h1;
    for (int i = 2; i < 6; i++) fb[i] = 8'h00;
    fb[6] = id[15:8];  fb[7] = id[7:0];
    fb[8] = code[15:8]; fb[9] = code[7:0];
    for (int i = 0; i < 4; i++) begin
      fb[10 + i] = a0[31 - 8*i -: 8];
      fb[14 + i] = a1[31 - 8*i -: 8];
    end
    for (int i = 18; i < 32; i++) fb[i] = 8'hEE;
  endtask

  task automatic hdr_only_words(input logic [7:0] exp_words, input string tag);
    for (int i = 0; i < 6; i++) fb[i] = 8'h00;
    send_frame(6);
    chk(tx_seen[5] == exp_words, tag, tx_seen[5], exp_words);
  endtask

  task automatic t_reset();
    chk(tx_byte == 8'h00 && !cmd_valid && !pay_valid && !hdr_err && !pay_done,
        "R10 outputs in reset", {tx_byte, cmd_valid, pay_valid}, 0);
    @(negedge clk); rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(tx_byte == 8'h01, "R10/R1 idle ready byte", tx_byte, 8'h01);
    hdr_only_words(8'd6, "R10 command phase after reset");
  endtask

  task automatic t_restart();
    int c0 = cmd_cnt;
    build_cmd(8'hFF, 8'h5A, 16'hAACA, 16'h0003, 32'h0, 32'h0);
    send_frame(20);
    chk(tx_seen[0] == 8'h01, "R1 status byte 0", tx_seen[0], 8'h01);
    chk(tx_seen[1] == 0 && tx_seen[2] == 0 && tx_seen[3] == 0, "R1 status bytes 1-3",
        {tx_seen[1], tx_seen[2], tx_seen[3]}, 0);
    chk(tx_seen[4] == 8'h80, "R1 marker byte", tx_seen[4], 8'h80);
    chk(tx_seen[5] == 8'd6, "R1 command word count", tx_seen[5], 6);
    chk(tx_seen[8] == 8'h00, "R1 post-header byte", tx_seen[8], 0);
    chk(cmd_cnt == c0 + 1, "R2/R7 restart accepted once", cmd_cnt - c0, 1);
    chk(last_sel == 4'b0100 && last_code == 16'h0003, "R4 restart decode",
        {last_sel, last_code}, {4'b0100, 16'h0003});
  endtask

  task automatic t_clear();
    build_cmd(8'h10, 8'h01, 16'hAACA, 16'h0004, 32'h1234_5678, 32'h9ABC_DEF0);
    send_frame(18);
    chk(last_a0 == 32'h1234_5678, "R3 first argument", last_a0, 32'h1234_5678);
    chk(last_a1 == 32'h9ABC_DEF0, "R3 second argument", last_a1, 32'h9ABC_DEF0);
    chk(last_sel == 4'b1000, "R4 clear decode", last_sel, 4'b1000);
    hdr_only_words(8'd6, "R11 clear keeps command phase");
  endtask

  task automatic t_upload_timing();
    build_cmd(8'h10, 8'h01, 16'hAACA, 16'h0002, 32'h0020_0000, 32'h0008_0000);
    @(negedge clk); cs_active = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 18; i++) begin
      rx_byte = fb[i]; rx_valid = 1'b1;
      @(negedge clk); rx_valid = 1'b0;
      if (i == 17) chk(cmd_valid && cmd_sel == 4'b0010, "R3 cmd_valid one clock after byte 17",
                       {cmd_valid, cmd_sel}, 5'b10010);
      @(negedge clk);
      if (i == 17) chk(!cmd_valid, "R3 cmd_valid single cycle", cmd_valid, 0);
      repeat (2) @(negedge clk);
    end
    cs_active = 1'b0;
    repeat (3) @(negedge clk);
    hdr_only_words(8'd6, "R11 upload keeps command phase");
  endtask

  task automatic t_bad_header();
    int c0 = cmd_cnt, e0 = err_cnt;
    build_cmd(8'h10, 8'h01, 16'hAACB, 16'h0001, 32'd8, 32'd0);
    send_frame(18);
    chk(err_cnt == e0 + 1 && cmd_cnt == c0, "R5 bad id gives error only",
        {err_cnt - e0, cmd_cnt - c0}, 64'h1_0000_0000);
    hdr_only_words(8'd6, "R5 stays in command phase");
  endtask

  task automatic t_unknown();
    int c0 = cmd_cnt;
    build_cmd(8'h10, 8'h01, 16'hAACA, 16'h0009, 32'd1, 32'd2);
    send_frame(18);
    chk(cmd_cnt == c0 + 1 && last_sel == 4'b0000 && last_code == 16'h0009,
        "R4 unknown code", {last_sel, last_code}, 16'h0009);
  endtask

  task automatic t_print();
    int p0 = pay_cnt, d0 = done_cnt;
    build_cmd(8'h10, 8'h01, 16'hAACA, 16'h0001, 32'd8, 32'h0000_0020);
    send_frame(18);
    chk(last_sel == 4'b0001 && last_a1 == 32'h20, "R4 print decode", {last_sel, last_a1}, 36'h1_0000_0020);
    for (int i = 0; i < 6; i++) fb[i] = 8'h00;
    for (int i = 0; i < 8; i++) fb[6 + i] = 8'h41 + 8'(i);
    fb[14] = 8'hEE; fb[15] = 8'hEE;
    send_frame(16);
    chk(tx_seen[5] == 8'd4, "R6 data word count", tx_seen[5], 4);
    chk(pay_cnt - p0 == 8, "R6/R7 payload byte count", pay_cnt - p0, 8);
    for (int i = 0; i < 8; i++)
      chk(pay_buf[(p0 + i) % 32] == 8'h41 + 8'(i), "R6 payload data",
          pay_buf[(p0 + i) % 32], 8'h41 + i);
    chk(done_cnt == d0 + 1 && done_at == p0 + 8, "R6 done with last byte",
        done_at - p0, 8);
    hdr_only_words(8'd6, "R6 back to command phase");
  endtask

  task automatic t_print_empty();
    int p0 = pay_cnt, d0 = done_cnt;
    build_cmd(8'h10, 8'h01, 16'hAACA, 16'h0001, 32'd0, 32'd0);
    send_frame(18);
    for (int i = 0; i < 10; i++) fb[i] = 8'h33;
    send_frame(10);
    chk(tx_seen[5] == 8'd0, "R6 empty word count", tx_seen[5], 0);
    chk(done_cnt == d0 + 1 && pay_cnt == p0, "R6 empty payload done",
        {done_cnt - d0, pay_cnt - p0}, 64'h1_0000_0000);
    hdr_only_words(8'd6, "R6 empty back to command");
  endtask

  task automatic t_not_ready();
    int c0 = cmd_cnt;
    target_ready = 1'b0;
    build_cmd(8'h10, 8'h01, 16'hAACA, 16'h0001, 32'd4, 32'd0);
    send_frame(18);
    target_ready = 1'b1;
    chk(tx_seen[0] == 8'h00, "R1 not-ready status byte", tx_seen[0], 0);
    chk(cmd_cnt == c0, "R8 frame ignored when not ready", cmd_cnt - c0, 0);
    hdr_only_words(8'd6, "R8 phase unchanged");
  endtask

  task automatic t_cs_drop();
    int c0 = cmd_cnt, e0 = err_cnt;
    build_cmd(8'h10, 8'h01, 16'h1234, 16'h5678, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    send_frame(11);
    build_cmd(8'h10, 8'h01, 16'hAACA, 16'h0004, 32'h0000_1000, 32'h0000_0200);
    send_frame(18);
    chk(cmd_cnt == c0 + 1 && err_cnt == e0, "R9 partial packet discarded",
        {cmd_cnt - c0, err_cnt - e0}, 64'h1_0000_0000);
    chk(last_a0 == 32'h1000 && last_a1 == 32'h200, "R9 fresh packet fields",
        last_a0, 32'h1000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    t_restart();
    t_clear();
    t_upload_timing();
    t_bad_header();
    t_unknown();
    t_print();
    t_print_empty();
    t_not_ready();
    t_cs_drop();
    summary();
    $finish;
  end
endmodule